// File: doc/BRIEF.md
# Mode-Controlled Tick Timer

This block is a small timer/counter. It holds an 8-bit count that steps up, steps down or returns to zero once per timer tick. A select input picks the tick source. The source can be one of five prescaled strobes from an external divider chain, or either edge of an outside pin, which is synchronised first. A select of zero halts the timer.

A three-bit mode input sets the counting pattern. In plain wrap mode the count runs freely. In compare-clear mode it returns to zero at a programmable match value. In up/down mode it bounces between the extremes. An overflow flag is set at the point that belongs to the active mode. The flag raises an interrupt request when that request is enabled, and it can be cleared through a register write or an acknowledge input.

The count is readable at all times, and a processor write can load it in any cycle, whether the timer runs or not. Status outputs show when the count sits at its maximum or at zero.

Top module: `tick_timer`

## Requirements
- R1: With mode codes 0 and 3 to 7 (plain wrap), each tick adds one modulo 256. A tick taken while the count is 0xFF wraps it to 0x00 and sets `ovfFlag`.
- R2: With `clkSel` = 0 no tick occurs, so the count holds even while `prescTick` strobes are active, and a processor write still loads the count.
- R3: When `cpuWrEn` is high, the next count equals `cpuWrData`. Any tick in that same cycle is discarded, and so is any flag set it would cause.
- R4: `clkSel` codes 1 to 5 take their tick from `prescTick[code-1]`. Strobes on the other `prescTick` bits leave the count unchanged.
- R5: `clkSel` code 7 ticks on a rising edge of `pinIn` and code 6 on a falling edge. The pin passes through a two-stage synchroniser and an edge register, so the count changes on the third rising clock edge after the pin changes. One pin edge yields exactly one tick, and the opposite edge yields none.
- R6: `atTop` is high exactly when the count is 0xFF, and `atBottom` is high exactly when the count is 0x00.
- R7: With mode code 2 (compare-clear), a tick taken while the count equals `cmpA` loads zero, and any other tick adds one. A tick taken at 0xFF sets `ovfFlag`.
- R8: With mode code 1 (up/down), counting runs upward. A tick at 0xFF moves the count to 0xFE and turns the direction downward. A tick at 0x00 while counting down moves the count to 0x01, turns the direction upward and sets `ovfFlag`. Entering 0x00 does not set the flag. In any other mode the direction returns to upward.
- R9: `ovfFlag` clears on `flagWr` with `flagWrData` = 1 or on `irqAck`. A flag write with data 0 has no effect, and a set in the same cycle wins over a clear.
- R10: `irq` equals `ovfFlag` AND `irqEn`.
- R11: After reset the count is 0x00, `ovfFlag` is 0 and the direction is upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Tick source select (0 halts) |
| prescTick | input | 5 | Single-cycle prescaled strobes, divide 1/8/64/256/1024 |
| pinIn | input | 1 | Asynchronous external count pin |
| wgMode | input | 3 | Counting pattern select |
| cmpA | input | 8 | Match value for compare-clear mode |
| cpuWrEn | input | 1 | Processor write strobe for the count |
| cpuWrData | input | 8 | Value to load into the count |
| flagWr | input | 1 | Processor write strobe for the flag bit |
| flagWrData | input | 1 | Written flag bit; 1 clears |
| irqAck | input | 1 | Interrupt acknowledge, clears the flag |
| irqEn | input | 1 | Interrupt enable |
| count | output | 8 | Current count value |
| atTop | output | 1 | Count is at maximum |
| atBottom | output | 1 | Count is zero |
| ovfFlag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `pinIn` and `flagWrData` hold a defined level at every clock edge. They also assume that the prescaled strobes and the write strobes change only between clock edges. The bench drives every input on the falling clock edge and samples outputs one falling edge later. It holds `pinIn` low through reset, so the synchroniser starts out settled and no edge is seen at release. Each pin edge is held for several cycles, which matches the slow external signal the edge detector expects.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam logic [2:0] WG_UPDOWN = 3'd1;
  localparam logic [2:0] WG_CMPCLR = 3'd2;

  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
    logic clr;
    logic setOvf;
    logic clrOvf;
    logic goDown;
    logic goUp;
  } cntCtl_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int W    = 8,
  parameter int NPRE = 5,
  parameter int CSW  = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CSW-1:0]  clkSel,
  input  logic [NPRE-1:0] prescTick,
  input  logic            pinIn,
  input  logic [2:0]      wgMode,
  input  logic [W-1:0]    cmpA,
  input  logic            cpuWrEn,
  input  logic            flagWr,
  input  logic            flagWrData,
  input  logic            irqAck,
  input  logic [W-1:0]    count,
  input  logic            dirDown,
  output cntCtl_t         ctl
);

  localparam logic [CSW-1:0] SEL_FALL = CSW'(NPRE + 1);
  localparam logic [CSW-1:0] SEL_RISE = CSW'(NPRE + 2);

  // two synchroniser stages plus one history stage
  logic [2:0] pinSh;
  logic pinRise, pinFall;

  always_ff @(posedge clk) begin
    if (!rstN) pinSh <= '0;
    else       pinSh <= {pinSh[1:0], pinIn};
  end

  assign pinRise = pinSh[1] & ~pinSh[2];
  assign pinFall = ~pinSh[1] & pinSh[2];

  logic [NPRE-1:0] preHit;
  genvar k;
  generate
    for (k = 0; k < NPRE; k++) begin : g_presel
      assign preHit[k] = (clkSel == CSW'(k + 1)) & prescTick[k];
    end
  endgenerate

  logic tick;
  always_comb begin
    tick = |preHit;
    if (clkSel == SEL_FALL) tick = pinFall;
    if (clkSel == SEL_RISE) tick = pinRise;
  end

  logic atMax, atZero;
  assign atMax  = (count == {W{1'b1}});
  assign atZero = (count == '0);

  always_comb begin
    ctl = '0;
    ctl.clrOvf = (flagWr & flagWrData) | irqAck;
    if (wgMode != WG_UPDOWN) ctl.goUp = dirDown;
    if (cpuWrEn) begin
      ctl.load = 1'b1;
    end else if (tick) begin
      case (wgMode)
        WG_UPDOWN: begin
          if (!dirDown) begin
            if (atMax) begin
              ctl.dec    = 1'b1;
              ctl.goDown = 1'b1;
            end else begin
              ctl.inc = 1'b1;
            end
          end else if (atZero) begin
            ctl.inc    = 1'b1;
            ctl.goUp   = 1'b1;
            ctl.setOvf = 1'b1;
          end else begin
            ctl.dec = 1'b1;
          end
        end
        WG_CMPCLR: begin
          if (count == cmpA) ctl.clr = 1'b1;
          else               ctl.inc = 1'b1;
          ctl.setOvf = atMax;
        end
        default: begin
          ctl.inc    = 1'b1;
          ctl.setOvf = atMax;
        end
      endcase
    end
  end

  // R5
  pin_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinRise |=> !pinRise);

  // R2
  stop_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0) |-> !(ctl.inc | ctl.dec | ctl.clr));

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntCtl_t      ctl,
  input  logic [W-1:0] ldData,
  output logic [W-1:0] count,
  output logic         dirDown,
  output logic         ovfFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      dirDown <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (ctl.load)     count <= ldData;
      else if (ctl.clr) count <= '0;
      else if (ctl.inc) count <= count + 1'b1;
      else if (ctl.dec) count <= count - 1'b1;

      if (ctl.goDown)    dirDown <= 1'b1;
      else if (ctl.goUp) dirDown <= 1'b0;

      if (ctl.setOvf)      ovfFlag <= 1'b1;
      else if (ctl.clrOvf) ovfFlag <= 1'b0;
    end
  end

  // R3
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(ctl.load) |-> count == $past(ldData));

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(ctl.clrOvf) && !$past(ctl.setOvf) |-> !ovfFlag);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int W    = 8,
  parameter int NPRE = 5,
  localparam int CSW = $clog2(NPRE + 3)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CSW-1:0]  clkSel,
  input  logic [NPRE-1:0] prescTick,
  input  logic            pinIn,
  input  logic [2:0]      wgMode,
  input  logic [W-1:0]    cmpA,
  input  logic            cpuWrEn,
  input  logic [W-1:0]    cpuWrData,
  input  logic            flagWr,
  input  logic            flagWrData,
  input  logic            irqAck,
  input  logic            irqEn,
  output logic [W-1:0]    count,
  output logic            atTop,
  output logic            atBottom,
  output logic            ovfFlag,
  output logic            irq
);

  cntCtl_t ctl;
  logic    dirDown;

  tick_timer_ctrl #(.W(W), .NPRE(NPRE), .CSW(CSW)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .prescTick(prescTick),
    .pinIn(pinIn), .wgMode(wgMode), .cmpA(cmpA), .cpuWrEn(cpuWrEn),
    .flagWr(flagWr), .flagWrData(flagWrData), .irqAck(irqAck),
    .count(count), .dirDown(dirDown), .ctl(ctl)
  );

  tick_timer_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ldData(cpuWrData),
    .count(count), .dirDown(dirDown), .ovfFlag(ovfFlag)
  );

  assign atTop    = (count == {W{1'b1}});
  assign atBottom = (count == '0);
  assign irq      = ovfFlag & irqEn;

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0) && !cpuWrEn |=> $stable(count));

  // R6
  ends_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({atTop, atBottom}));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] clkSel;
  logic [4:0] prescTick;
  logic       pinIn;
  logic [2:0] wgMode;
  logic [7:0] cmpA;
  logic       cpuWrEn;
  logic [7:0] cpuWrData;
  logic       flagWr;
  logic       flagWrData;
  logic       irqAck;
  logic       irqEn;
  logic [7:0] count;
  logic       atTop, atBottom, ovfFlag, irq;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .prescTick(prescTick),
    .pinIn(pinIn), .wgMode(wgMode), .cmpA(cmpA), .cpuWrEn(cpuWrEn),
    .cpuWrData(cpuWrData), .flagWr(flagWr), .flagWrData(flagWrData),
    .irqAck(irqAck), .irqEn(irqEn), .count(count), .atTop(atTop),
    .atBottom(atBottom), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    cpuWrEn = 1'b1; cpuWrData = v;
    cyc();
    cpuWrEn = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    prescTick = 5'(1 << idx);
    cyc(n);
    prescTick = '0;
  endtask

  task automatic clearFlag();
    flagWr = 1'b1; flagWrData = 1'b1;
    cyc();
    flagWr = 1'b0; flagWrData = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 count", count, 0);
    chk("R11 flag", ovfFlag, 0);
    chk("R6 bottom", atBottom, 1);
    chk("R6 top", atTop, 0);
  endtask

  task automatic t_normal();
    wgMode = 3'd0; clkSel = 3'd1;
    pulse(0, 10);
    chk("R1 ten ticks", count, 10);
    load(8'hFE);
    pulse(0, 1);
    chk("R6 top at ff", atTop, 1);
    chk("R1 no flag before wrap", ovfFlag, 0);
    pulse(0, 1);
    chk("R1 wrap count", count, 0);
    chk("R1 wrap flag", ovfFlag, 1);
    irqEn = 1'b0; cyc();
    chk("R10 irq masked", irq, 0);
    irqEn = 1'b1; cyc();
    chk("R10 irq on", irq, 1);
    flagWr = 1'b1; flagWrData = 1'b0; cyc(); flagWr = 1'b0;
    chk("R9 write zero ignored", ovfFlag, 1);
    clearFlag();
    chk("R9 write one clears", ovfFlag, 0);
    wgMode = 3'd5; load(8'h20);
    pulse(0, 3);
    chk("R1 mode 5 counts up", count, 8'h23);
    wgMode = 3'd0;
  endtask

  task automatic t_wrprio();
    load(8'hFF);
    prescTick = 5'b00001; cpuWrEn = 1'b1; cpuWrData = 8'h40;
    cyc();
    cpuWrEn = 1'b0; prescTick = '0;
    chk("R3 write wins", count, 8'h40);
    chk("R3 no wrap flag", ovfFlag, 0);
  endtask

  task automatic t_stop();
    load(8'h11);
    clkSel = 3'd0; prescTick = 5'b11111;
    cyc(5);
    prescTick = '0;
    chk("R2 halted", count, 8'h11);
    load(8'h33);
    chk("R2 write while halted", count, 8'h33);
  endtask

  task automatic t_presel();
    for (int code = 1; code <= 5; code++) begin
      load(8'h00);
      clkSel = 3'(code);
      for (int j = 0; j < 5; j++) if (j != code - 1) pulse(j, 1);
      chk($sformatf("R4 others ignored code %0d", code), count, 0);
      pulse(code - 1, 2);
      chk($sformatf("R4 selected code %0d", code), count, 2);
    end
  endtask

  task automatic t_pin();
    clkSel = 3'd7; load(8'h00);
    pinIn = 1'b1;
    cyc(2);
    chk("R5 rise not yet", count, 0);
    cyc(1);
    chk("R5 rise counted", count, 1);
    cyc(5);
    chk("R5 one tick per edge", count, 1);
    pinIn = 1'b0; cyc(6);
    chk("R5 fall ignored on code 7", count, 1);
    clkSel = 3'd6;
    pinIn = 1'b1; cyc(6);
    chk("R5 rise ignored on code 6", count, 1);
    pinIn = 1'b0; cyc(3);
    chk("R5 fall counted", count, 2);
    cyc(4);
    chk("R5 fall once", count, 2);
  endtask

  task automatic t_cmpclr();
    clkSel = 3'd1; wgMode = 3'd2; cmpA = 8'h05;
    load(8'h00);
    pulse(0, 5);
    chk("R7 reach match", count, 5);
    pulse(0, 1);
    chk("R7 cleared at match", count, 0);
    chk("R7 no flag at match", ovfFlag, 0);
    load(8'hFF);
    pulse(0, 1);
    chk("R7 wrap count", count, 0);
    chk("R7 wrap flag", ovfFlag, 1);
    clearFlag();
  endtask

  task automatic t_updown();
    clkSel = 3'd1; wgMode = 3'd1;
    load(8'hFD);
    pulse(0, 2);
    chk("R8 up to top", count, 8'hFF);
    pulse(0, 1);
    chk("R8 reverse at top", count, 8'hFE);
    pulse(0, 1);
    chk("R8 counting down", count, 8'hFD);
    load(8'h02);
    pulse(0, 2);
    chk("R8 down to zero", count, 0);
    chk("R8 no flag on entry", ovfFlag, 0);
    pulse(0, 1);
    chk("R8 reverse at bottom", count, 1);
    chk("R8 flag at bottom", ovfFlag, 1);
    pulse(0, 1);
    chk("R8 up again", count, 2);
    irqAck = 1'b1; cyc(); irqAck = 1'b0;
    chk("R9 ack clears", ovfFlag, 0);
    load(8'hFF); pulse(0, 1);
    wgMode = 3'd0; cyc();
    load(8'h10); pulse(0, 1);
    chk("R8 direction up outside mode", count, 8'h11);
    wgMode = 3'd1; pulse(0, 1);
    chk("R8 restart upward", count, 8'h12);
  endtask

  initial begin
    rstN = 1'b0; clkSel = '0; prescTick = '0; pinIn = 1'b0; wgMode = '0;
    cmpA = '0; cpuWrEn = 1'b0; cpuWrData = '0; flagWr = 1'b0;
    flagWrData = 1'b0; irqAck = 1'b0; irqEn = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc();
    t_reset();
    t_normal();
    t_wrprio();
    t_stop();
    t_presel();
    t_pin();
    t_cmpclr();
    t_updown();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
      $finish;
    end
  end

endmodule